// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer with Software Force

This block is a timer peripheral with one free-running counter and two output compare channels, each driving one output pin. A channel watches for the counter reaching its programmed compare value. When that happens, the channel copies its level bit from the control register to its pin, raises its status flag, and contributes to the interrupt line if its enable bit is set. Software can also drive a pin at any time by writing a one to the channel's force strobe. A forced update moves the pin only. It leaves the flag and the interrupt alone.

All access goes through a byte-wide register port with a 3-bit address. Register writes take effect at the clock edge. Read data is a combinational function of the address, and the read strobe only matters for the side effects of the flag-clear sequence. The compare registers are plain storage that hardware never alters, so they can hold data when a channel is not in use. A compare value is written high byte first. Matching on that channel is held off until the low byte arrives, so no match can occur on a half-written value.

Top module: `ocmp_timer`

## Requirements
- R1: The counter is 16 bits wide, resets to 0 and increments once per prescaler tick, which by default is every clock. Its high byte reads at address 2 and its low byte at address 3.
- R2: The control register is at address 0, with these bits: bit 0 is the channel 1 level, bit 1 is the channel 2 level, bit 3 is the channel 1 force strobe, bit 4 is the channel 2 force strobe, bit 6 is the channel 1 interrupt enable and bit 7 is the channel 2 interrupt enable. The force bits always read as 0, and the register resets to 0.
- R3: A control write with a channel's force bit at one drives that channel's pin, from the next clock, to the level value carried in that same write.
- R4: A forced update never sets a compare flag and never raises `irq`.
- R5: A control write with a channel's force bit at zero leaves that pin unchanged, even if the write changes the level bit.
- R6: When the counter equals a channel's compare value, on the following clock the pin takes the channel's level bit and the channel's flag sets. Flags read at address 1, bit 0 for channel 1 and bit 1 for channel 2. `irq` is high while any flag is set together with its enable.
- R7: Writing a channel's compare high byte stops that channel from matching until its low byte is written. A channel also cannot match after reset until its low byte is first written.
- R8: The compare registers read back exactly as written: channel 1 high byte at address 4 and low byte at address 5, channel 2 high byte at address 6 and low byte at address 7. Neither reset nor the counter changes them.
- R9: A flag clears only when the status register is first read with `bus_rd` while that flag is set, and then that channel's low compare byte is read (with `bus_rd`) or written. An access to the low byte without the prior status read leaves the flag set.
- R10: If a force write and a match on the same channel fall in the same cycle, the pin takes the newly written level bit and the flag still sets.
- R11: Reset drives both pins, both flags and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for flag-clear side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cmp_out | output | 2 | Compare output pins, bit 0 is channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- The force bits read back as zero.
- A force strobe lands the level carried in its write on the pin.
- A flag only rises one cycle after the counter equalled the compare value, and never while the channel is held off by a pending high-byte write.
- The compare registers change only under a write to their own addresses.
- `irq` is never high without a flag.
- A flag only falls after an access to its low compare byte.

Only the directed scenarios can show the rest:
- The exact cycle of a match.
- That a level change without a force leaves the pin alone.
- The two-step flag-clear ordering.
- That compare values survive a reset.
- The outcome when a force and a match collide in one cycle.

// File: rtl/ocmp_pkg.sv
`timescale 1ns/1ps
package ocmp_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_CNTH = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNTL = 3'd3;
   localparam logic [ADDR_W-1:0] A_CMP0 = 3'd4;

   localparam int LVL_BASE = 0;
   localparam int FRC_BASE = 3;
   localparam int IE_BASE  = 6;

   function automatic logic [ADDR_W-1:0] cmp_hi_addr(input int ch);
      return A_CMP0 + ADDR_W'(2 * ch);
   endfunction

   function automatic logic [ADDR_W-1:0] cmp_lo_addr(input int ch);
      return A_CMP0 + ADDR_W'(2 * ch + 1);
   endfunction
endpackage

// File: rtl/ocmp_counter.sv
`timescale 1ns/1ps
module ocmp_counter #(
   parameter int CNT_W      = 16,
   parameter int PRESC_LOG2 = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fresh_o
);
   logic tick;

   generate
      if (PRESC_LOG2 < 0 || PRESC_LOG2 > 12) begin : g_bad_presc
         $error("ocmp_counter: PRESC_LOG2 out of range");
      end
      if (PRESC_LOG2 == 0) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [PRESC_LOG2-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_q + PRESC_LOG2'(1);
         end
         assign tick = &div_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         fresh_o <= 1'b0;
      end else begin
         fresh_o <= tick;
         if (tick) cnt_o <= cnt_o + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ocmp_channel.sv
`timescale 1ns/1ps
module ocmp_channel #(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             fresh_i,
   input  logic             wr_hi_i,
   input  logic             wr_lo_i,
   input  logic             lo_touch_i,
   input  logic             stat_rd_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic             lvl_i,
   input  logic             force_i,
   output logic [CNT_W-1:0] cmp_o,
   output logic             flag_o,
   output logic             pin_o,
   output logic             inh_o
);
   localparam int HI_W = CNT_W - BUS_W;

   logic hit;
   logic arm_q;
   logic clr;

   always_ff @(posedge clk) begin
      if (wr_hi_i) cmp_o[CNT_W-1:BUS_W] <= wdata_i[HI_W-1:0];
      if (wr_lo_i) cmp_o[BUS_W-1:0]     <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inh_o <= 1'b1;
      else if (wr_lo_i) inh_o <= 1'b0;
      else if (wr_hi_i) inh_o <= 1'b1;
   end

   assign hit = fresh_i && !inh_o && (cnt_i == cmp_o);
   assign clr = arm_q && lo_touch_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (hit)      flag_o <= 1'b1;
         else if (clr) flag_o <= 1'b0;

         if (clr)                       arm_q <= 1'b0;
         else if (stat_rd_i && flag_o)  arm_q <= 1'b1;
         else if (!flag_o)              arm_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pin_o <= 1'b0;
      else if (force_i || hit)   pin_o <= lvl_i;
   end
endmodule

// File: rtl/ocmp_timer.sv
`timescale 1ns/1ps
module ocmp_timer
   import ocmp_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int BUS_W      = 8,
   parameter int NUM_CH     = 2,
   parameter int PRESC_LOG2 = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] cmp_out,
   output logic              irq
);
   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("ocmp_timer: counter must span exactly two bus bytes");
      end
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("ocmp_timer: control layout holds one or two channels");
      end
      if (BUS_W < IE_BASE + NUM_CH) begin : g_bad_bus
         $error("ocmp_timer: bus too narrow for control layout");
      end
   endgenerate

   logic [CNT_W-1:0]             cnt_q;
   logic                         fresh;
   logic [NUM_CH-1:0]            lvl_q;
   logic [NUM_CH-1:0]            ie_q;
   logic [NUM_CH-1:0]            flag_q;
   logic [NUM_CH-1:0]            inh_q;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_val;
   logic                         wr_ctrl;
   logic                         stat_rd;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign stat_rd = bus_rd && (bus_addr == A_STAT);

   ocmp_counter #(.CNT_W(CNT_W), .PRESC_LOG2(PRESC_LOG2)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_o   (cnt_q),
      .fresh_o (fresh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         ie_q  <= '0;
      end else if (wr_ctrl) begin
         for (int k = 0; k < NUM_CH; k++) begin
            lvl_q[k] <= bus_wdata[LVL_BASE + k];
            ie_q[k]  <= bus_wdata[IE_BASE + k];
         end
      end
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      localparam logic [ADDR_W-1:0] HI_A = cmp_hi_addr(k);
      localparam logic [ADDR_W-1:0] LO_A = cmp_lo_addr(k);
      logic lvl_new;
      logic frc;
      logic lo_hit;

      assign lo_hit  = (bus_addr == LO_A);
      assign lvl_new = wr_ctrl ? bus_wdata[LVL_BASE + k] : lvl_q[k];
      assign frc     = wr_ctrl && bus_wdata[FRC_BASE + k];

      ocmp_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .cnt_i      (cnt_q),
         .fresh_i    (fresh),
         .wr_hi_i    (bus_wr && (bus_addr == HI_A)),
         .wr_lo_i    (bus_wr && lo_hit),
         .lo_touch_i ((bus_wr || bus_rd) && lo_hit),
         .stat_rd_i  (stat_rd),
         .wdata_i    (bus_wdata),
         .lvl_i      (lvl_new),
         .force_i    (frc),
         .cmp_o      (cmp_val[k]),
         .flag_o     (flag_q[k]),
         .pin_o      (cmp_out[k]),
         .inh_o      (inh_q[k])
      );
   end

   assign irq = |(flag_q & ie_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            for (int k = 0; k < NUM_CH; k++) begin
               bus_rdata[LVL_BASE + k] = lvl_q[k];
               bus_rdata[IE_BASE + k]  = ie_q[k];
            end
         end
         A_STAT: bus_rdata[NUM_CH-1:0] = flag_q;
         A_CNTH: bus_rdata = cnt_q[CNT_W-1:BUS_W];
         A_CNTL: bus_rdata = cnt_q[BUS_W-1:0];
         default: begin
            for (int k = 0; k < NUM_CH; k++) begin
               if (bus_addr == cmp_hi_addr(k)) bus_rdata = cmp_val[k][CNT_W-1:BUS_W];
               if (bus_addr == cmp_lo_addr(k)) bus_rdata = cmp_val[k][BUS_W-1:0];
            end
         end
      endcase
   end
endmodule

// File: rtl/ocmp_checker.sv
`timescale 1ns/1ps
module ocmp_checker
   import ocmp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int BUS_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [1:0]        cmp_out,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp0,
   input logic [CNT_W-1:0]  cmp1,
   input logic [1:0]        flag,
   input logic [1:0]        inh
);
   // R2
   assert_force_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTRL) |-> (bus_rdata[FRC_BASE+1:FRC_BASE] == 2'b00));

   // R3
   assert_force_pin0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[FRC_BASE])
      |=> (cmp_out[0] == $past(bus_wdata[LVL_BASE])));
   assert_force_pin1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && bus_wdata[FRC_BASE+1])
      |=> (cmp_out[1] == $past(bus_wdata[LVL_BASE+1])));

   // R6
   assert_flag0_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[0]) |-> $past(cnt == cmp0));
   assert_flag1_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[1]) |-> $past(cnt == cmp1));
   assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag != 2'b00));

   // R7
   assert_inhibit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[0]) |-> !$past(inh[0]));
   assert_inhibit1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[1]) |-> !$past(inh[1]));

   // R8
   assert_cmp0_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == cmp_hi_addr(0) || bus_addr == cmp_lo_addr(0)))
      |=> $stable(cmp0));
   assert_cmp1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == cmp_hi_addr(1) || bus_addr == cmp_lo_addr(1)))
      |=> $stable(cmp1));

   // R9
   assert_flag0_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[0]) |-> $past((bus_wr || bus_rd) && bus_addr == cmp_lo_addr(0)));
   assert_flag1_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[1]) |-> $past((bus_wr || bus_rd) && bus_addr == cmp_lo_addr(1)));
endmodule

bind ocmp_timer ocmp_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_ocmp_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cmp_out   (cmp_out),
   .irq       (irq),
   .cnt       (cnt_q),
   .cmp0      (cmp_val[0]),
   .cmp1      (cmp_val[1]),
   .flag      (flag_q),
   .inh       (inh_q)
);

// File: tb/test_ocmp_timer.sv
`timescale 1ns/1ps
module test_ocmp_timer;
   localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNTH = 3'd2, CNTL = 3'd3;
   localparam logic [2:0] C1H = 3'd4, C1L = 3'd5, C2H = 3'd6, C2L = 3'd7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cmp_out;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   int c0_val = 0;
   int c1_val = 0;

   ocmp_timer i_ocmp_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cmp_out(cmp_out), .irq(irq)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic set_cmp(input int ch, input int val);
      wr(ch == 0 ? C1H : C2H, 8'(val >> 8));
      wr(ch == 0 ? C1L : C2L, 8'(val));
   endtask

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   task automatic t_reset;
      int v;
      int h;
      int l;
      peek(CTRL, v); chk("R2 ctrl reset", v, 0);
      peek(STAT, v); chk("R11 flags reset", v, 0);
      chk("R11 pins reset", int'(cmp_out), 0);
      chk("R11 irq reset", int'(irq), 0);
      peek(CNTH, h); peek(CNTL, l);
      chk("R1 counter after reset", (h << 8) | l, cyc & 16'hFFFF);
   endtask

   task automatic t_counter;
      int h;
      int l;
      repeat (37) @(negedge clk);
      peek(CNTH, h); peek(CNTL, l);
      chk("R1 counter runs", (h << 8) | l, cyc & 16'hFFFF);
   endtask

   task automatic t_cmp_rw;
      int v;
      wr(C1H, 8'hA5); wr(C1L, 8'h3C); wr(C2H, 8'h5A); wr(C2L, 8'hC3);
      peek(C1H, v); chk("R8 c1 hi", v, 8'hA5);
      peek(C1L, v); chk("R8 c1 lo", v, 8'h3C);
      peek(C2H, v); chk("R8 c2 hi", v, 8'h5A);
      peek(C2L, v); chk("R8 c2 lo", v, 8'hC3);
   endtask

   task automatic t_force;
      int v;
      wr(CTRL, 8'h49);
      chk("R3 force ch1 pin", int'(cmp_out), 2'b01);
      peek(STAT, v); chk("R4 force no flag", v, 0);
      chk("R4 force no irq", int'(irq), 0);
      peek(CTRL, v); chk("R2 force bits read zero", v, 8'h41);
      wr(CTRL, 8'h52);
      chk("R3 R5 force ch2 only", int'(cmp_out), 2'b11);
      peek(CTRL, v); chk("R2 ctrl readback", v, 8'h42);
      wr(CTRL, 8'h40);
      chk("R5 no force keeps pins", int'(cmp_out), 2'b11);
      peek(STAT, v); chk("R4 still no flag", v, 0);
   endtask

   task automatic t_match_ch1;
      int c;
      int v;
      c = cyc + 10;
      set_cmp(0, c);
      c0_val = c;
      wait_cyc(c);
      chk("R6 pin before match", int'(cmp_out[0]), 1);
      peek(STAT, v); chk("R6 no flag before match", v & 1, 0);
      @(negedge clk);
      chk("R6 pin at match", int'(cmp_out[0]), 0);
      peek(STAT, v); chk("R6 flag at match", v & 1, 1);
      chk("R6 irq enabled", int'(irq), 1);
   endtask

   task automatic t_clear;
      int v;
      rd(C1L);
      peek(STAT, v); chk("R9 lo access alone keeps flag", v & 1, 1);
      rd(STAT);
      peek(STAT, v); chk("R9 status read keeps flag", v & 1, 1);
      rd(C1L);
      peek(STAT, v); chk("R9 sequence clears flag", v & 1, 0);
      chk("R9 irq drops", int'(irq), 0);
   endtask

   task automatic t_match_ch2;
      int c;
      int v;
      c = cyc + 10;
      set_cmp(1, c);
      wait_cyc(c + 1);
      chk("R6 ch2 pin", int'(cmp_out[1]), 0);
      peek(STAT, v); chk("R6 ch2 flag", v & 2, 2);
      chk("R6 irq masked", int'(irq), 0);
      rd(STAT);
      wr(C2L, 8'h77);
      c1_val = (c & 16'hFF00) | 8'h77;
      peek(STAT, v); chk("R9 write lo clears", v & 2, 0);
   endtask

   task automatic t_inhibit;
      int t;
      int c;
      int v;
      wr(CTRL, 8'h41);
      t = cyc + 30;
      wr(C1H, 8'((t >> 8) + 1));
      wr(C1L, 8'(t));
      wr(C1H, 8'(t >> 8));
      wait_cyc(t + 3);
      chk("R7 inhibited pin", int'(cmp_out[0]), 0);
      peek(STAT, v); chk("R7 inhibited flag", v & 1, 0);
      c = cyc + 10;
      set_cmp(0, c);
      c0_val = c;
      wait_cyc(c + 1);
      chk("R7 match resumes pin", int'(cmp_out[0]), 1);
      peek(STAT, v); chk("R7 match resumes flag", v & 1, 1);
      rd(STAT); rd(C1L);
   endtask

   task automatic t_collide;
      int c;
      int v;
      c = cyc + 10;
      set_cmp(0, c);
      c0_val = c;
      wait_cyc(c);
      wr(CTRL, 8'h48);
      chk("R10 pin takes new level", int'(cmp_out[0]), 0);
      peek(STAT, v); chk("R10 flag still set", v & 1, 1);
   endtask

   task automatic t_reset_keep;
      int v;
      int h;
      int l;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R11 pins after reset", int'(cmp_out), 0);
      chk("R11 irq after reset", int'(irq), 0);
      peek(STAT, v); chk("R11 flags after reset", v, 0);
      peek(CTRL, v); chk("R2 ctrl after reset", v, 0);
      peek(CNTH, h); peek(CNTL, l);
      chk("R1 counter restarts", (h << 8) | l, cyc & 16'hFFFF);
      peek(C1H, v); chk("R8 c1 hi kept", v, (c0_val >> 8) & 8'hFF);
      peek(C1L, v); chk("R8 c1 lo kept", v, c0_val & 8'hFF);
      peek(C2L, v); chk("R8 c2 lo kept", v, c1_val & 8'hFF);
      wr(CTRL, 8'h01);
      wait_cyc((c0_val & 16'hFFFF) + 2);
      chk("R7 no match before first lo write", int'(cmp_out[0]), 0);
      peek(STAT, v); chk("R7 no flag before first lo write", v & 1, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counter();
      t_cmp_rw();
      t_force();
      t_match_ch1();
      t_clear();
      t_match_ch2();
      t_inhibit();
      t_collide();
      t_reset_keep();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule